// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Timer

This block governs the enable of a regulator output while the output is under sustained overload. It watches a synchronized overcurrent comparator flag. An overload only counts as a fault once it has lasted longer than a qualification window. When a fault counts, the block forces the output off for a long fixed interval and raises an overload status flag for that whole interval. Afterwards it always restarts the output through a soft-start ramp, and it keeps watching the comparator during that ramp.

All time is measured in pulses of a one-millisecond tick enable input. A static-limit mode input turns the timed shutdown-and-retry behaviour off, and the output then simply stays enabled. A low device enable parks the block in an idle state with the output off and every timer cleared. Every output is a register and changes on the clock edge that follows the condition that causes it.

Top module: `hiccup_fault_timer`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_enable`, `soft_start` and `overload_flag` are all low.
- R2: The edge after `enable` is seen high (with `static_limit` low) in idle raises `out_enable` and `soft_start`. `soft_start` then stays high for exactly 20 ticks, after which `soft_start` drops and `out_enable` stays high.
- R3: An overcurrent counts as a fault only on the 52nd consecutive tick with `oc_flag` high, i.e. after more than 51 ms. On the edge of that tick `out_enable` falls and `overload_flag` rises.
- R4: If `oc_flag` is low for any cycle, the qualification count returns to zero. A later overcurrent again needs 52 consecutive ticks.
- R5: After a fault, `out_enable` stays low and `overload_flag` stays high for exactly 900 ticks. An overcurrent during this period has no effect.
- R6: On the edge of the 900th off tick, `overload_flag` clears and a new 20-tick soft-start begins (`out_enable` and `soft_start` high).
- R7: Overcurrent ticks during soft-start count toward qualification. The count carries on into normal running, and a persisting fault re-enters the 900-tick off state with the flag set.
- R8: With `enable` low, the next edge drives all three outputs low and clears all timers. Raising `enable` again starts a fresh full 20-tick soft-start.
- R9: With `enable` and `static_limit` high, the next edge gives `out_enable` high and `soft_start` and `overload_flag` low. `oc_flag` is then ignored. Dropping `static_limit` with `oc_flag` low leaves the output running with a zero qualification count.
- R10: Timers advance only in cycles where `tick_1ms` is high. With the tick low, the off period holds and an overcurrent neither qualifies nor is cleared. A low `oc_flag` still clears the qualification count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle enable pulse, once per millisecond |
| enable | input | 1 | Device enable; low shuts the output down |
| static_limit | input | 1 | High selects static limiting; hiccup timing disabled |
| oc_flag | input | 1 | Synchronized overcurrent comparator output |
| out_enable | output | 1 | Regulator output enable |
| soft_start | output | 1 | High while the soft-start ramp runs |
| overload_flag | output | 1 | High during the forced-off period |

## Verification
The overcurrent flag is held high for exactly 51 ticks and then one more tick. This separates "more than 51 ms" from an off-by-one qualification window. A second run drops the flag for one cycle after 30 ticks, which shows whether the count clears or only pauses. Holding the flag high through the whole off period, and then into the following soft-start, shows both that the off time ignores overcurrent and that soft-start ticks count toward qualification. Stretches with the tick held low tell timers that count clock cycles apart from timers that count ticks, and enable and static-mode toggles in several states check the override priority.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOFT = 2'd1,
    ST_RUN  = 2'd2,
    ST_OFF  = 2'd3
  } hic_state_e;
endpackage

// File: rtl/hiccup_tick_timer.sv
module hiccup_tick_timer #(
  parameter int LIMIT = 20,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && (cnt != W'(LIMIT - 1)))
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(LIMIT - 1)); // R10
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       static_limit,
  input  logic       qual_fire,
  input  logic       off_fire,
  input  logic       ss_fire,
  output hic_state_e state,
  output logic       out_enable,
  output logic       soft_start,
  output logic       overload_flag
);
  hic_state_e nxt;

  always_comb begin
    nxt = state;
    if (!enable)
      nxt = ST_IDLE;
    else if (static_limit)
      nxt = ST_RUN;
    else begin
      unique case (state)
        ST_IDLE: nxt = ST_SOFT;
        ST_SOFT: if (qual_fire) nxt = ST_OFF;
                 else if (ss_fire) nxt = ST_RUN;
        ST_RUN:  if (qual_fire) nxt = ST_OFF;
        ST_OFF:  if (off_fire) nxt = ST_SOFT;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      out_enable    <= 1'b0;
      soft_start    <= 1'b0;
      overload_flag <= 1'b0;
    end else begin
      state         <= nxt;
      out_enable    <= (nxt == ST_SOFT) || (nxt == ST_RUN);
      soft_start    <= (nxt == ST_SOFT);
      overload_flag <= (nxt == ST_OFF);
    end
  end

  AST_FLAG_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    overload_flag |-> !out_enable); // R5
  AST_SOFT_IMPLIES_ON: assert property (@(posedge clk) disable iff (rst)
    soft_start |-> out_enable); // R2
endmodule

// File: rtl/hiccup_fault_timer.sv
module hiccup_fault_timer
  import hiccup_pkg::*;
#(
  parameter int QUAL_TICKS = 51,
  parameter int OFF_TICKS  = 900,
  parameter int SS_TICKS   = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic enable,
  input  logic static_limit,
  input  logic oc_flag,
  output logic out_enable,
  output logic soft_start,
  output logic overload_flag
);
  localparam int QUAL_LIMIT = QUAL_TICKS + 1;

  hic_state_e state;
  logic qual_last, off_last, ss_last;
  logic watching;

  assign watching = (state == ST_SOFT) || (state == ST_RUN);

  hiccup_tick_timer #(.LIMIT(QUAL_LIMIT)) u_qual (
    .clk (clk), .rst (rst),
    .clr (!enable || static_limit || !watching || !oc_flag),
    .inc (tick_1ms),
    .last(qual_last)
  );

  hiccup_tick_timer #(.LIMIT(OFF_TICKS)) u_off (
    .clk (clk), .rst (rst),
    .clr (!enable || (state != ST_OFF)),
    .inc (tick_1ms),
    .last(off_last)
  );

  hiccup_tick_timer #(.LIMIT(SS_TICKS)) u_ss (
    .clk (clk), .rst (rst),
    .clr (!enable || (state != ST_SOFT)),
    .inc (tick_1ms),
    .last(ss_last)
  );

  hiccup_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .static_limit (static_limit),
    .qual_fire    (tick_1ms && oc_flag && qual_last),
    .off_fire     (tick_1ms && off_last),
    .ss_fire      (tick_1ms && ss_last),
    .state        (state),
    .out_enable   (out_enable),
    .soft_start   (soft_start),
    .overload_flag(overload_flag)
  );

  AST_DISABLE_SHUTS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!out_enable && !soft_start && !overload_flag)); // R8
  AST_STATIC_ON: assert property (@(posedge clk) disable iff (rst)
    (enable && static_limit) |=> (out_enable && !overload_flag && !soft_start)); // R9
  AST_FAULT_NEEDS_OC: assert property (@(posedge clk) disable iff (rst)
    $rose(overload_flag) |-> ($past(oc_flag) && $past(tick_1ms))); // R3
  AST_OFF_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (overload_flag && enable && !static_limit && !tick_1ms) |=> overload_flag); // R10
  AST_RETRY_SOFT: assert property (@(posedge clk) disable iff (rst)
    ($fell(overload_flag) && $past(enable) && !$past(static_limit)) |-> soft_start); // R6
endmodule

// File: tb/hiccup_fault_timer_tb.sv
module hiccup_fault_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 1'b1;
  logic enable = 1'b0;
  logic static_limit = 1'b0;
  logic oc_flag = 1'b0;
  logic out_enable, soft_start, overload_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_fault_timer u_dut (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .enable(enable),
    .static_limit(static_limit), .oc_flag(oc_flag),
    .out_enable(out_enable), .soft_start(soft_start),
    .overload_flag(overload_flag)
  );

  // {tick, en, static, oc, edges[11:0], exp_out, exp_ss, exp_flag, req[3:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {4'b1100, 12'd1,   3'b110, 4'd2},   // R2 enter soft-start
    {4'b1100, 12'd19,  3'b110, 4'd2},   // R2 still soft after 20 ticks total
    {4'b1100, 12'd1,   3'b100, 4'd2},   // R2 soft-start ends at 20
    {4'b1101, 12'd51,  3'b100, 4'd3},   // R3 51 ticks is not a fault
    {4'b1101, 12'd1,   3'b001, 4'd3},   // R3 52nd tick trips
    {4'b1100, 12'd899, 3'b001, 4'd5},   // R5 off for 899 ticks
    {4'b1100, 12'd1,   3'b110, 4'd6},   // R6 retry via soft-start
    {4'b1101, 12'd30,  3'b100, 4'd7},   // R7 oc across soft and run
    {4'b1100, 12'd1,   3'b100, 4'd4},   // R4 drop clears count
    {4'b1101, 12'd51,  3'b100, 4'd4},   // R4 full window needed again
    {4'b1101, 12'd1,   3'b001, 4'd4},   // R4 trips at 52
    {4'b1101, 12'd900, 3'b110, 4'd5},   // R5 oc ignored while off
    {4'b1101, 12'd51,  3'b100, 4'd7},   // R7 soft-start ticks counted
    {4'b1101, 12'd1,   3'b001, 4'd7},   // R7 re-enters off
    {4'b1001, 12'd1,   3'b000, 4'd8},   // R8 enable low
    {4'b1111, 12'd1,   3'b100, 4'd9},   // R9 static mode on
    {4'b1111, 12'd100, 3'b100, 4'd9},   // R9 oc ignored
    {4'b1100, 12'd1,   3'b100, 4'd9},   // R9 leave static, keep running
    {4'b0101, 12'd100, 3'b100, 4'd10},  // R10 no tick, no qualification
    {4'b1101, 12'd51,  3'b100, 4'd10},  // R10 count was not advanced
    {4'b1101, 12'd1,   3'b001, 4'd10},  // R10 trips
    {4'b0100, 12'd300, 3'b001, 4'd10},  // R10 off holds without ticks
    {4'b1100, 12'd10,  3'b001, 4'd5},   // R5 still off
    {4'b1000, 12'd1,   3'b000, 4'd8},   // R8 disable mid-off
    {4'b1100, 12'd1,   3'b110, 4'd8},   // R8 fresh soft-start
    {4'b1100, 12'd20,  3'b100, 4'd8}    // R8 full 20-tick ramp
  };

  task automatic check(input int req, input logic eo, input logic es,
                       input logic ef, input string what);
    checks++;
    if (out_enable !== eo || soft_start !== es || overload_flag !== ef) begin
      errors++;
      $display("FAIL R%0d %s: out=%b ss=%b flag=%b expected out=%b ss=%b flag=%b",
               req, what, out_enable, soft_start, overload_flag, eo, es, ef);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state with enable high
    @(negedge clk);
    enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, "during reset");
    enable = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, "first edge after reset");

    for (int i = 0; i < NVEC; i++) begin
      tick_1ms     = VEC[i][22];
      enable       = VEC[i][21];
      static_limit = VEC[i][20];
      oc_flag      = VEC[i][19];
      repeat (int'(VEC[i][18:7])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][3:0]), VEC[i][6], VEC[i][5], VEC[i][4],
            $sformatf("vector %0d", i));
    end

    // R1 reset mid-run clears outputs, then restart through soft-start
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0, "reset while running");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(2, 1'b1, 1'b1, 1'b0, "soft-start after reset");

    // R9 static mode overrides the off state immediately
    oc_flag = 1'b1;
    repeat (72) @(posedge clk);
    @(negedge clk);
    check(3, 1'b0, 1'b0, 1'b1, "fault after soft-start plus run");
    static_limit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(9, 1'b1, 1'b0, 1'b0, "static overrides off");

    finish_run();
  end
endmodule